// File: doc/BRIEF.md
# Circular Load Queue Entry Tracker

This block keeps the bookkeeping state of a circular load queue with a parameterised number of entries. For every entry it holds an occupancy bit and three status flags: the address has arrived, the data has arrived, and the request has been issued. It also keeps a tail pointer, which marks where the next group of loads goes, and a head pointer, which marks the oldest entry still occupied.

A producer reserves a group of consecutive entries in one handshake by giving the number of loads in the group. Other logic reports progress through per-entry strobes: address written, data written, issue taken, and load finished. The tracker returns the occupancy and status vectors. It also returns a per-entry vector of loads that are ready to be checked for issue. Payloads, routing and hazard checks are outside this block.

The head is not a counter. On every cycle it is found again by searching the next occupancy vector cyclically, starting at the current head. Completions may therefore arrive in any order.

Top module: `lq_entry_tracker`

## Requirements
- R1: The next occupancy of entry i is `grp_wen[i] OR (occupied[i] AND NOT done_clr[i])`. When a group write and a finish strobe hit the same entry in the same cycle, the entry ends up occupied.
- R2: On an accepted group the tail becomes `(tail + grp_count) mod ENTRIES`. In any other cycle the tail holds.
- R3: The registered head is the first occupied entry of the next occupancy vector, searching cyclically from the current head. `head_oh` is the one-hot form of the head, with bit k set for head k.
- R4: Each of the address-valid, data-valid and issued flags follows `next = (set OR current) AND NOT grp_wen[i]`. A group write clears all three flags of that entry, even when a set strobe arrives in the same cycle.
- R5: `req_ok_vec[i]` equals `occupied[i] AND addr_ok[i] AND NOT issued[i]`.
- R6: An accepted group occupies the `grp_count` consecutive entries that start at the tail, wrapping from entry ENTRIES-1 to entry 0.
- R7: `grp_ready` is high only when `grp_count <= ENTRIES` and the `grp_count` entries starting at the tail are all unoccupied. A request that is not ready changes no state.
- R8: When the next occupancy vector is empty, the head keeps its value.
- R9: A synchronous active-low reset clears every occupancy and status bit and sets both pointers to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| grp_valid | input | 1 | Group allocation request |
| grp_count | input | CNT_W | Number of loads in the group |
| grp_ready | output | 1 | Group can be accepted this cycle |
| addr_set | input | ENTRIES | Per-entry address-written strobe |
| data_set | input | ENTRIES | Per-entry data-written strobe |
| issue_set | input | ENTRIES | Per-entry issue-taken strobe |
| done_clr | input | ENTRIES | Per-entry load-finished strobe |
| head_idx | output | PTR_W | Oldest occupied entry |
| head_oh | output | ENTRIES | One-hot head |
| tail_idx | output | PTR_W | Next entry to allocate |
| alloc_vec | output | ENTRIES | Occupancy bits |
| addr_ok_vec | output | ENTRIES | Address-valid flags |
| data_ok_vec | output | ENTRIES | Data-valid flags |
| issued_vec | output | ENTRIES | Issued flags |
| req_ok_vec | output | ENTRIES | Loads ready for dependency checking |

## Verification
The state outputs are registered. Occupancy, flags, tail, head and head one-hot therefore show the effect of a stimulus one clock edge after the strobes are driven. `req_ok_vec` follows from those registers with no further delay, and `grp_ready` is combinational on the current state and `grp_count`. The bench drives strobes just after a rising edge and checks `grp_ready` before the next edge. It reads the registered results one time step after that edge, which is exactly one cycle after the stimulus.

// File: rtl/lq_track_pkg.sv
// Package lq_track_pkg
// Shared ring arithmetic for the load-queue tracker.
// Assumes every index it is given is already below n.
package lq_track_pkg;
    // Distance from base forward to idx on a ring of n slots
    function automatic int ring_offset(input int idx, input int base, input int n);
        return (idx - base + n) % n;
    endfunction

    // Index reached by stepping forward by step on a ring of n slots
    function automatic int ring_step(input int base, input int step, input int n);
        return (base + step) % n;
    endfunction
endpackage

// File: rtl/lq_alloc_window.sv
// Module lq_alloc_window
// Builds the window of grp_count entries that starts at the tail and decides
// whether a group fits. The group fits when every slot of the window is free.
// It returns the per-entry write enables for an accepted group.
// Assumes tail < ENTRIES.
module lq_alloc_window
    import lq_track_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int PTR_W   = 3,
    parameter int CNT_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PTR_W-1:0]   tail,
    input  logic [CNT_W-1:0]   count,
    input  logic               valid,
    input  logic [ENTRIES-1:0] occupied,
    output logic               ready,
    output logic [ENTRIES-1:0] wen
);
    logic [ENTRIES-1:0] window;

    // Mark the slots lying within count steps of the tail
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            window[i] = ring_offset(i, int'(tail), ENTRIES) < int'(count);
        end
    end

    // Accept only when the window is free and not larger than the ring
    always_comb begin
        ready = (int'(count) <= ENTRIES) && ((window & occupied) == '0);
        wen   = window & {ENTRIES{valid && ready}};
    end

    AST_READY_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (int'(count) <= ENTRIES)); // R7
    AST_WEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (wen & occupied) == '0); // R6
endmodule

// File: rtl/lq_oldest_pick.sv
// Module lq_oldest_pick
// Cyclic priority search. It returns the first set bit of vec, starting at
// start and wrapping past the top. found is low when vec is all zero, and
// idx then equals start.
// Assumes start < ENTRIES.
module lq_oldest_pick
    import lq_track_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int PTR_W   = 3
) (
    input  logic [PTR_W-1:0]   start,
    input  logic [ENTRIES-1:0] vec,
    output logic               found,
    output logic [PTR_W-1:0]   idx
);
    // Walk the ring from start and keep the first set bit
    always_comb begin
        found = 1'b0;
        idx   = start;
        for (int off = 0; off < ENTRIES; off++) begin
            if (!found && vec[ring_step(int'(start), off, ENTRIES)]) begin
                found = 1'b1;
                idx   = PTR_W'(ring_step(int'(start), off, ENTRIES));
            end
        end
    end
endmodule

// File: rtl/lq_status_bits.sv
// Module lq_status_bits
// A vector of set/clear flags, one per entry. A set strobe raises a flag.
// The allocation write enable clears it, and the clear wins over a set.
// Assumes a synchronous active-low reset.
module lq_status_bits #(
    parameter int ENTRIES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] set,
    input  logic [ENTRIES-1:0] wen,
    output logic [ENTRIES-1:0] flags
);
    // Update the flags: set or hold, then clear where an entry is written
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (set | flags) & ~wen;
    end

    for (genvar i = 0; i < ENTRIES; i++) begin : g_chk
        AST_WEN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            wen[i] |=> !flags[i]); // R4
        AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
            (set[i] && !wen[i]) |=> flags[i]); // R4
    end
endmodule

// File: rtl/lq_entry_tracker.sv
// Module lq_entry_tracker
// Tracks occupancy, status flags, head and tail of a circular load queue.
// A group handshake reserves consecutive entries at the tail. Completions
// may come in any order. The head is found again each cycle by a cyclic
// search. Assumes ENTRIES >= 2.
module lq_entry_tracker #(
    parameter int ENTRIES = 8,
    parameter int PTR_W   = $clog2(ENTRIES),
    parameter int CNT_W   = $clog2(ENTRIES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               grp_valid,
    input  logic [CNT_W-1:0]   grp_count,
    output logic               grp_ready,
    input  logic [ENTRIES-1:0] addr_set,
    input  logic [ENTRIES-1:0] data_set,
    input  logic [ENTRIES-1:0] issue_set,
    input  logic [ENTRIES-1:0] done_clr,
    output logic [PTR_W-1:0]   head_idx,
    output logic [ENTRIES-1:0] head_oh,
    output logic [PTR_W-1:0]   tail_idx,
    output logic [ENTRIES-1:0] alloc_vec,
    output logic [ENTRIES-1:0] addr_ok_vec,
    output logic [ENTRIES-1:0] data_ok_vec,
    output logic [ENTRIES-1:0] issued_vec,
    output logic [ENTRIES-1:0] req_ok_vec
);
    logic [ENTRIES-1:0] occ_q, occ_d, grp_wen;
    logic [PTR_W-1:0]   tail_q, tail_d, head_q, pick_idx;
    logic               pick_found, accept;

    lq_alloc_window #(.ENTRIES(ENTRIES), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_win (
        .clk(clk), .rst_n(rst_n), .tail(tail_q), .count(grp_count),
        .valid(grp_valid), .occupied(occ_q), .ready(grp_ready), .wen(grp_wen)
    );

    // Next occupancy: a group write wins over a finish strobe
    always_comb occ_d = grp_wen | (occ_q & ~done_clr);

    lq_oldest_pick #(.ENTRIES(ENTRIES), .PTR_W(PTR_W)) u_pick (
        .start(head_q), .vec(occ_d), .found(pick_found), .idx(pick_idx)
    );

    // Tail moves forward by the group size on acceptance
    always_comb begin
        accept = grp_valid && grp_ready;
        tail_d = accept ? PTR_W'((int'(tail_q) + int'(grp_count)) % ENTRIES) : tail_q;
    end

    // Pointer and occupancy registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q  <= '0;
            tail_q <= '0;
            head_q <= '0;
        end else begin
            occ_q  <= occ_d;
            tail_q <= tail_d;
            head_q <= pick_found ? pick_idx : head_q;
        end
    end

    lq_status_bits #(.ENTRIES(ENTRIES)) u_addr (
        .clk(clk), .rst_n(rst_n), .set(addr_set), .wen(grp_wen), .flags(addr_ok_vec));
    lq_status_bits #(.ENTRIES(ENTRIES)) u_data (
        .clk(clk), .rst_n(rst_n), .set(data_set), .wen(grp_wen), .flags(data_ok_vec));
    lq_status_bits #(.ENTRIES(ENTRIES)) u_iss (
        .clk(clk), .rst_n(rst_n), .set(issue_set), .wen(grp_wen), .flags(issued_vec));

    // Output decode
    always_comb begin
        head_idx   = head_q;
        head_oh    = ENTRIES'(1) << head_q;
        tail_idx   = tail_q;
        alloc_vec  = occ_q;
        req_ok_vec = occ_q & addr_ok_vec & ~issued_vec;
    end

    AST_TAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(grp_valid && grp_ready) |=> $stable(tail_q)); // R2
    AST_HEAD_ON_OCC: assert property (@(posedge clk) disable iff (!rst_n)
        (|occ_q) |-> occ_q[head_q]); // R3
    AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|occ_q) && !(grp_valid && grp_ready)) |=> $stable(head_q)); // R8
    for (genvar i = 0; i < ENTRIES; i++) begin : g_occ
        AST_WEN_OCCUPIES: assert property (@(posedge clk) disable iff (!rst_n)
            grp_wen[i] |=> occ_q[i]); // R1
        AST_CLR_FREES: assert property (@(posedge clk) disable iff (!rst_n)
            (done_clr[i] && !grp_wen[i]) |=> !occ_q[i]); // R1
    end
endmodule

// File: tb/lq_entry_tracker_tb.sv
module lq_entry_tracker_tb;
    localparam int N = 8;
    localparam int PW = 3;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          grp_valid = 1'b0;
    logic [CW-1:0] grp_count = '0;
    logic          grp_ready;
    logic [N-1:0]  addr_set = '0, data_set = '0, issue_set = '0, done_clr = '0;
    logic [PW-1:0] head_idx, tail_idx;
    logic [N-1:0]  head_oh, alloc_vec, addr_ok_vec, data_ok_vec, issued_vec, req_ok_vec;
    int            n_chk = 0, n_fail = 0;
    bit            done = 1'b0;

    always #10 clk = ~clk;

    lq_entry_tracker #(.ENTRIES(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .grp_valid(grp_valid), .grp_count(grp_count),
        .grp_ready(grp_ready), .addr_set(addr_set), .data_set(data_set),
        .issue_set(issue_set), .done_clr(done_clr), .head_idx(head_idx),
        .head_oh(head_oh), .tail_idx(tail_idx), .alloc_vec(alloc_vec),
        .addr_ok_vec(addr_ok_vec), .data_ok_vec(data_ok_vec),
        .issued_vec(issued_vec), .req_ok_vec(req_ok_vec)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One clock: inputs already driven, sample 1 ns after the edge, clear strobes
    task automatic step();
        @(posedge clk);
        #1;
        grp_valid = 1'b0; grp_count = '0;
        addr_set = '0; data_set = '0; issue_set = '0; done_clr = '0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; step(); step();
        check("R9 alloc", alloc_vec, 0);
        check("R9 tail", tail_idx, 0);
        check("R9 head", head_idx, 0);
        check("R9 flags", addr_ok_vec | data_ok_vec | issued_vec, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_first_group();
        grp_valid = 1; grp_count = 3; #1;
        check("R7 ready", grp_ready, 1);
        step();
        check("R6 alloc", alloc_vec, 8'h07);
        check("R2 tail", tail_idx, 3);
        check("R3 head_oh", head_oh, 8'h01);
    endtask

    task automatic t_status();
        addr_set = 8'h03; issue_set = 8'h02; data_set = 8'h04;
        step();
        check("R4 addr", addr_ok_vec, 8'h03);
        check("R4 issued", issued_vec, 8'h02);
        check("R4 data", data_ok_vec, 8'h04);
        check("R5 req_ok", req_ok_vec, 8'h01);
    endtask

    task automatic t_out_of_order_done();
        done_clr = 8'h01; step();
        check("R1 clr", alloc_vec, 8'h06);
        check("R3 head", head_idx, 1);
        check("R5 req_ok after clr", req_ok_vec, 8'h00);
    endtask

    task automatic t_reject_then_wrap();
        grp_valid = 1; grp_count = 7; #1;
        check("R7 not ready", grp_ready, 0);
        step();
        check("R7 tail kept", tail_idx, 3);
        check("R7 alloc kept", alloc_vec, 8'h06);
        grp_valid = 1; grp_count = 6; #1;
        check("R7 ready 6", grp_ready, 1);
        step();
        check("R2 tail wrap", tail_idx, 1);
        check("R6 alloc wrap", alloc_vec, 8'hFF);
        check("R4 realloc clears", addr_ok_vec, 8'h02);
        check("R3 head kept", head_idx, 1);
    endtask

    task automatic t_empty_and_priority();
        done_clr = 8'hFF; step();
        check("R1 all free", alloc_vec, 8'h00);
        check("R8 head holds", head_idx, 1);
        grp_valid = 1; grp_count = 2; done_clr = 8'h02; addr_set = 8'h04; #1;
        check("R7 ready 2", grp_ready, 1);
        step();
        check("R1 wen beats clr", alloc_vec, 8'h06);
        check("R4 wen beats set", addr_ok_vec, 8'h00);
        check("R4 issued cleared", issued_vec, 8'h00);
        check("R2 tail", tail_idx, 3);
    endtask

    task automatic t_full_ring();
        done_clr = 8'h02; step();
        check("R3 head 2", head_idx, 2);
        grp_valid = 1; grp_count = 8; #1;
        check("R7 full blocked", grp_ready, 0);
        step();
        done_clr = 8'h04; step();
        check("R8 empty head", head_idx, 2);
        grp_valid = 1; grp_count = 8; step();
        check("R6 full ring", alloc_vec, 8'hFF);
        check("R2 full wrap", tail_idx, 3);
        done_clr = 8'hFC; step();
        check("R3 cyclic wrap", head_idx, 0);
        check("R3 head_oh wrap", head_oh, 8'h01);
        grp_valid = 1; grp_count = 9; #1;
        check("R7 oversize", grp_ready, 0);
        step();
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #1;
        t_reset();
        t_first_group();
        t_status();
        t_out_of_order_done();
        t_reject_then_wrap();
        t_empty_and_priority();
        t_full_ring();
        t_reset();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule